// File: doc/BRIEF.md
# Command Transfer State Machine

This block runs the command and response exchange between software and an execution engine through two registers: a byte-wide data FIFO and a status word. Software claims the buffer with a command-ready write, streams command bytes in through the FIFO, and issues go once the block reports that the whole packet has arrived. The block learns the packet length from the command header as the bytes arrive. When go is accepted, it sends a start strobe and the byte count to the execution engine. The engine writes its response into the shared buffer and signals done. Software then drains the response through the FIFO, guided by a burst count in the status word.

Only the locality that currently owns the interface may use it. An owner flag arrives with every access, and ownership is decided outside the block. Interrupt delivery is also outside the block: it only emits single-cycle event pulses for command-ready, status-valid and data-available. Read data for every access appears one cycle after the access is presented. A command can be abandoned at any stage with a command-ready write. The abandon takes effect at once while bytes are being received. During execution it cancels the engine and waits for done.

Top module: `cmd_xfer_fsm`

## Requirements
- R1: In idle, a command-ready write (status bit 6) moves the block to ready, sets status bit 6 and pulses `evt_cmd_ready`. In ready, the same write changes nothing and pulses no event.
- R2: The first FIFO write in ready enters reception with valid (bit 7) and expect (bit 3) set. FIFO writes in idle, execution or completion leave the status word and burst count unchanged.
- R3: A command byte is stored only while expect is set and fewer than `BUF_BYTES` bytes are held. A byte that arrives when the buffer is full clears expect and leaves valid set.
- R4: The command length is the big-endian 32-bit value in bytes 2..5. After more than 5 bytes, expect stays set while that length exceeds the byte count and clears once the count reaches it. `evt_sts_valid` pulses only if valid was clear.
- R5: A status write is acted on only when the value, masked to bits 6, 5 and 1, has exactly one of those bits set. Go (bit 5) is accepted only in reception with expect clear. It pulses `be_start` for one cycle with `be_len` equal to the bytes received.
- R6: `be_done` in execution enters completion with valid and data-available (bit 4) set and pulses `evt_data_avail` and `evt_sts_valid`. The read position returns to 0.
- R7: A FIFO read in completion with data-available set returns the next response byte. The read of the last byte clears data-available, keeps valid and pulses `evt_sts_valid`. Any other FIFO read returns 0x000000FF.
- R8: Status bits 23:8 hold the burst count. With data-available set, this is the number of unread response bytes, where the response length is the big-endian value in response bytes 2..5, capped at `BUF_BYTES`. Otherwise it is `BUF_BYTES` minus the current offset.
- R9: A status read flagged as single-byte caps the burst count at 0xFF.
- R10: A response-retry write (bit 1) in completion rewinds the read position to 0 and sets valid and data-available.
- R11: A command-ready write in completion enters ready, clears data-available, sets command-ready with `evt_cmd_ready` if it was clear, and resets the offset to 0.
- R12: A command-ready write in reception returns to ready at once, with command-ready set, offset 0 and `evt_cmd_ready`. In execution it pulses `be_cancel`; the next `be_done` then enters ready with `evt_cmd_ready` and no data events.
- R13: Status bits 27:26 always read `FAMILY`. Bit 2 (self-test done) is set by `be_done` with `be_selftest` high, and no later status update clears it.
- R14: Accesses without ownership change no state. A status read without ownership returns 0xFFFFFFFF and a FIFO read without ownership returns 0x000000FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_fifo | input | 1 | 1 = data FIFO, 0 = status word |
| acc_byte | input | 1 | Read is single-byte wide (caps burst count) |
| acc_owner | input | 1 | Accessing locality currently owns the interface |
| acc_wdata | input | 32 | Write data (FIFO uses bits 7:0) |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| be_start | output | 1 | One-cycle start strobe to the execution engine |
| be_len | output | $clog2(BUF_BYTES)+1 | Command byte count with the start strobe |
| be_cancel | output | 1 | One-cycle cancel request to the engine |
| be_done | input | 1 | Engine finished (response in buffer) |
| be_selftest | input | 1 | With done: self-test has completed |
| rsp_we | input | 1 | Engine writes a response byte |
| rsp_addr | input | $clog2(BUF_BYTES) | Response byte address |
| rsp_byte | input | 8 | Response byte |
| evt_cmd_ready | output | 1 | Command-ready event pulse |
| evt_sts_valid | output | 1 | Status-valid event pulse |
| evt_data_avail | output | 1 | Data-available event pulse |

## Verification
The assertions assume a well-behaved engine. It raises `be_done` only while a command is executing, and it writes response bytes only in that phase, with bytes 2..5 in ascending address order so that the streamed header capture sees them in sequence. They also assume at most one register access per cycle. The stimulus holds to this: done and response writes are driven only after a start strobe has been observed, response bytes go out in address order, and every access is a single-cycle task that finishes before the next one begins.

// File: rtl/cxf_pkg.sv
`timescale 1ns/1ps
package cxf_pkg;

  typedef enum logic [2:0] {
    CX_IDLE  = 3'd0,
    CX_READY = 3'd1,
    CX_RECV  = 3'd2,
    CX_EXEC  = 3'd3,
    CX_COMPL = 3'd4
  } cx_state_e;

  // status word bit positions (decoded by software)
  localparam int B_VALID    = 7;
  localparam int B_CMDRDY   = 6;
  localparam int B_GO       = 5;
  localparam int B_DAVAIL   = 4;
  localparam int B_EXPECT   = 3;
  localparam int B_SELFTEST = 2;
  localparam int B_RETRY    = 1;

  localparam logic [31:0] CMD_MASK = (32'd1 << B_CMDRDY) | (32'd1 << B_GO) | (32'd1 << B_RETRY);
  localparam logic [31:0] NO_DATA  = 32'h0000_00FF;

  // Fold one streamed byte into a big-endian length held in bytes 2..5.
  function automatic logic [31:0] hdr_shift(input logic [31:0] cur,
                                            input logic [31:0] idx,
                                            input logic [7:0]  b);
    if (idx >= 32'd2 && idx <= 32'd5) return {cur[23:0], b};
    return cur;
  endfunction

  // Burst count: unread response bytes, or free buffer space.
  function automatic logic [15:0] burst_calc(input logic        davail,
                                             input logic [31:0] rlen,
                                             input logic [31:0] off,
                                             input logic [31:0] bufsz,
                                             input logic        byte_rd);
    logic [31:0] avail;
    if (davail) avail = (rlen > off) ? (rlen - off) : 32'd0;
    else        avail = (bufsz > off) ? (bufsz - off) : 32'd0;
    if (byte_rd && avail > 32'd255) avail = 32'd255;
    return avail[15:0];
  endfunction

endpackage

// File: rtl/cxf_buffer.sv
`timescale 1ns/1ps
module cxf_buffer #(
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cxf_hdr_reg.sv
`timescale 1ns/1ps
module cxf_hdr_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        ld,
  input  logic [31:0] nxt,
  output logic [31:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else if (ld)       q <= nxt;
  end
endmodule

// File: rtl/cxf_sts_fmt.sv
`timescale 1ns/1ps
module cxf_sts_fmt #(
  parameter logic [1:0] FAMILY = 2'b01
) (
  input  logic        valid,
  input  logic        cmdrdy,
  input  logic        davail,
  input  logic        expect_f,
  input  logic        selftest,
  input  logic [15:0] burst,
  output logic [31:0] word
);
  assign word = {4'b0, FAMILY, 2'b0, burst,
                 valid, cmdrdy, 1'b0, davail, expect_f, selftest, 2'b0};
endmodule

// File: rtl/cmd_xfer_fsm.sv
`timescale 1ns/1ps
module cmd_xfer_fsm
  import cxf_pkg::*;
#(
  parameter int         BUF_BYTES = 4096,
  parameter logic [1:0] FAMILY    = 2'b01,
  localparam int        AW        = $clog2(BUF_BYTES),
  localparam int        OW        = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic          acc_fifo,
  input  logic          acc_byte,
  input  logic          acc_owner,
  input  logic [31:0]   acc_wdata,
  output logic          rd_valid,
  output logic [31:0]   rd_data,
  output logic          be_start,
  output logic [OW-1:0] be_len,
  output logic          be_cancel,
  input  logic          be_done,
  input  logic          be_selftest,
  input  logic          rsp_we,
  input  logic [AW-1:0] rsp_addr,
  input  logic [7:0]    rsp_byte,
  output logic          evt_cmd_ready,
  output logic          evt_sts_valid,
  output logic          evt_data_avail
);
  localparam logic [31:0] BUF32 = 32'(BUF_BYTES);

  cx_state_e st_q, st_n;
  logic [OW-1:0] off_q, off_n;
  logic valid_q, cmdrdy_q, davail_q, expect_q, selft_q, abort_q;
  logic valid_n, cmdrdy_n, davail_n, expect_n, selft_n, abort_n;
  logic evt_cr_n, evt_sv_n, evt_da_n, be_start_n, be_cancel_n, rd_valid_n;
  logic [31:0] rd_data_n;
  logic [OW-1:0] be_len_n;

  // buffer and header capture controls
  logic          bw_en;
  logic [AW-1:0] bw_addr;
  logic [7:0]    bw_data, brd;
  logic          ch_clr, ch_ld, rh_clr, rh_ld;
  logic [31:0]   ch_nxt, rh_nxt, cmd_len_q, rsp_len_q, rlen32;

  // named events for the checker
  logic done_hit, go_ok, owner_acc;
  logic [31:0] sv_masked;
  logic [15:0] burst_now;
  logic [31:0] sts_word;

  // temporaries of the FIFO-write path
  logic t_exp, t_val, t_cr, t_da, t_need;
  logic [OW-1:0] t_off;
  logic [31:0]   t_len;

  cxf_buffer #(.DEPTH(BUF_BYTES)) u_buf (
    .clk(clk), .we(bw_en), .waddr(bw_addr), .wdata(bw_data),
    .raddr(off_q[AW-1:0]), .rdata(brd)
  );

  cxf_hdr_reg u_cmd_hdr (
    .clk(clk), .rst_n(rst_n), .clr(ch_clr), .ld(ch_ld), .nxt(ch_nxt), .q(cmd_len_q)
  );

  cxf_hdr_reg u_rsp_hdr (
    .clk(clk), .rst_n(rst_n), .clr(rh_clr), .ld(rh_ld), .nxt(rh_nxt), .q(rsp_len_q)
  );

  cxf_sts_fmt #(.FAMILY(FAMILY)) u_fmt (
    .valid(valid_q), .cmdrdy(cmdrdy_q), .davail(davail_q), .expect_f(expect_q),
    .selftest(selft_q), .burst(burst_now), .word(sts_word)
  );

  assign rlen32    = (rsp_len_q > BUF32) ? BUF32 : rsp_len_q;
  assign burst_now = burst_calc(davail_q, rlen32, 32'(off_q), BUF32, acc_byte);
  assign done_hit  = (st_q == CX_EXEC) && be_done;
  assign owner_acc = acc_valid && acc_owner && !done_hit;
  assign sv_masked = acc_wdata & CMD_MASK;
  assign go_ok     = owner_acc && acc_write && !acc_fifo &&
                     (sv_masked == (32'd1 << B_GO)) && (st_q == CX_RECV) && !expect_q;

  always_comb begin
    st_n = st_q;   off_n = off_q;
    valid_n = valid_q; cmdrdy_n = cmdrdy_q; davail_n = davail_q;
    expect_n = expect_q; selft_n = selft_q; abort_n = abort_q;
    evt_cr_n = 1'b0; evt_sv_n = 1'b0; evt_da_n = 1'b0;
    be_start_n = 1'b0; be_cancel_n = 1'b0; be_len_n = be_len;
    rd_valid_n = 1'b0; rd_data_n = rd_data;
    bw_en = 1'b0; bw_addr = rsp_addr; bw_data = rsp_byte;
    ch_clr = 1'b0; ch_ld = 1'b0; ch_nxt = cmd_len_q;
    rh_clr = 1'b0; rh_ld = 1'b0;
    rh_nxt = hdr_shift(rsp_len_q, 32'(rsp_addr), rsp_byte);
    t_exp = expect_q; t_val = valid_q; t_cr = cmdrdy_q; t_da = davail_q;
    t_need = 1'b0; t_off = off_q; t_len = cmd_len_q;

    // engine writes its response into the shared buffer
    if (st_q == CX_EXEC && rsp_we) begin
      bw_en = 1'b1;
      rh_ld = 1'b1;
    end

    if (done_hit) begin
      selft_n = selft_q | be_selftest;
      off_n   = '0;
      expect_n = 1'b0;
      if (abort_q) begin
        st_n = CX_READY; ch_clr = 1'b1; abort_n = 1'b0;
        valid_n = 1'b0; davail_n = 1'b0; cmdrdy_n = 1'b1;
        evt_cr_n = 1'b1;
      end else begin
        st_n = CX_COMPL;
        valid_n = 1'b1; davail_n = 1'b1; cmdrdy_n = 1'b0;
        evt_da_n = 1'b1; evt_sv_n = 1'b1;
      end
    end else if (acc_valid && !acc_owner) begin
      if (!acc_write) begin
        rd_valid_n = 1'b1;
        rd_data_n  = acc_fifo ? NO_DATA : 32'hFFFF_FFFF;
      end
    end else if (owner_acc && acc_write && !acc_fifo) begin
      // status write: exactly one command bit after masking
      if (sv_masked == (32'd1 << B_CMDRDY)) begin
        unique case (st_q)
          CX_IDLE, CX_RECV: begin
            st_n = CX_READY; off_n = '0; ch_clr = 1'b1;
            valid_n = 1'b0; davail_n = 1'b0; expect_n = 1'b0; cmdrdy_n = 1'b1;
            evt_cr_n = 1'b1;
          end
          CX_EXEC: begin
            abort_n = 1'b1; be_cancel_n = 1'b1;
          end
          CX_COMPL: begin
            st_n = CX_READY; off_n = '0; ch_clr = 1'b1;
            if (!cmdrdy_q) begin
              valid_n = 1'b0; expect_n = 1'b0; cmdrdy_n = 1'b1;
              evt_cr_n = 1'b1;
            end
            davail_n = 1'b0;
          end
          default: ;
        endcase
      end else if (go_ok) begin
        st_n = CX_EXEC; be_start_n = 1'b1; be_len_n = off_q; rh_clr = 1'b1;
      end else if (sv_masked == (32'd1 << B_RETRY) && st_q == CX_COMPL) begin
        off_n = '0;
        valid_n = 1'b1; davail_n = 1'b1; cmdrdy_n = 1'b0; expect_n = 1'b0;
      end
    end else if (owner_acc && acc_write && acc_fifo) begin
      if (st_q == CX_READY || st_q == CX_RECV) begin
        if (st_q == CX_READY) begin
          st_n = CX_RECV;
          t_exp = 1'b1; t_val = 1'b1; t_cr = 1'b0; t_da = 1'b0;
        end
        if (t_exp) begin
          if (32'(off_q) < BUF32) begin
            bw_en = 1'b1; bw_addr = off_q[AW-1:0]; bw_data = acc_wdata[7:0];
            t_len = hdr_shift(cmd_len_q, 32'(off_q), acc_wdata[7:0]);
            ch_ld = 1'b1; ch_nxt = t_len;
            t_off = off_q + OW'(1);
          end else begin
            t_exp = 1'b0; t_val = 1'b1; t_cr = 1'b0; t_da = 1'b0;
          end
        end
        if (32'(t_off) > 32'd5 && t_exp) begin
          t_need = !t_val;
          t_val = 1'b1; t_cr = 1'b0; t_da = 1'b0;
          t_exp = (t_len > 32'(t_off));
        end
        off_n = t_off; expect_n = t_exp; valid_n = t_val;
        cmdrdy_n = t_cr; davail_n = t_da; evt_sv_n = t_need;
      end
    end else if (owner_acc && !acc_write && !acc_fifo) begin
      rd_valid_n = 1'b1;
      rd_data_n  = sts_word;
    end else if (owner_acc && !acc_write && acc_fifo) begin
      rd_valid_n = 1'b1;
      if (st_q == CX_COMPL && davail_q) begin
        rd_data_n = {24'h0, brd};
        off_n = off_q + OW'(1);
        if (32'(off_q) + 32'd1 >= rlen32) begin
          davail_n = 1'b0; valid_n = 1'b1; cmdrdy_n = 1'b0; expect_n = 1'b0;
          evt_sv_n = 1'b1;
        end
      end else begin
        rd_data_n = NO_DATA;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= CX_IDLE; off_q <= '0;
      valid_q <= 1'b0; cmdrdy_q <= 1'b0; davail_q <= 1'b0;
      expect_q <= 1'b0; selft_q <= 1'b0; abort_q <= 1'b0;
      evt_cmd_ready <= 1'b0; evt_sts_valid <= 1'b0; evt_data_avail <= 1'b0;
      be_start <= 1'b0; be_cancel <= 1'b0; be_len <= '0;
      rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      st_q <= st_n; off_q <= off_n;
      valid_q <= valid_n; cmdrdy_q <= cmdrdy_n; davail_q <= davail_n;
      expect_q <= expect_n; selft_q <= selft_n; abort_q <= abort_n;
      evt_cmd_ready <= evt_cr_n; evt_sts_valid <= evt_sv_n; evt_data_avail <= evt_da_n;
      be_start <= be_start_n; be_cancel <= be_cancel_n; be_len <= be_len_n;
      rd_valid <= rd_valid_n; rd_data <= rd_data_n;
    end
  end

endmodule

// File: rtl/cmd_xfer_chk.sv
`timescale 1ns/1ps
module cmd_xfer_chk
  import cxf_pkg::*;
#(
  parameter int  BUF_BYTES = 4096,
  localparam int OW        = $clog2(BUF_BYTES) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input cx_state_e     st,
  input logic          expect_f,
  input logic          davail,
  input logic          cmdrdy,
  input logic [OW-1:0] off,
  input logic          be_start,
  input logic [OW-1:0] be_len,
  input logic          evt_cmd_ready,
  input logic          evt_data_avail
);
  AST_CMDRDY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmd_ready |-> (st == CX_READY) && cmdrdy);  // R1
  AST_EXPECT_IN_RECV: assert property (@(posedge clk) disable iff (!rst_n)
    expect_f |-> st == CX_RECV);  // R2
  AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(off) <= 32'(BUF_BYTES));  // R3
  AST_START_LEN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> 32'(be_len) >= 32'd6);  // R4
  AST_START_FROM_RECV: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |-> (st == CX_EXEC) && ($past(st) == CX_RECV));  // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |=> !be_start);  // R5
  AST_DATA_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_data_avail |-> (st == CX_COMPL) && davail);  // R6
  AST_DAVAIL_IN_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    davail |-> st == CX_COMPL);  // R7
endmodule

bind cmd_xfer_fsm cmd_xfer_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .expect_f(expect_q), .davail(davail_q),
  .cmdrdy(cmdrdy_q), .off(off_q), .be_start(be_start), .be_len(be_len),
  .evt_cmd_ready(evt_cmd_ready), .evt_data_avail(evt_data_avail)
);

// File: tb/cmd_xfer_fsm_test.sv
`timescale 1ns/1ps
module cmd_xfer_fsm_test;
  localparam int         BUF = 4096;
  localparam logic [1:0] FAM = 2'b01;
  localparam int         AW  = $clog2(BUF);
  localparam int         OW  = AW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, acc_fifo = 0, acc_byte = 0, acc_owner = 0;
  logic [31:0] acc_wdata = '0;
  logic rd_valid, be_start, be_cancel, evt_cmd_ready, evt_sts_valid, evt_data_avail;
  logic [31:0] rd_data;
  logic [OW-1:0] be_len;
  logic be_done = 0, be_selftest = 0, rsp_we = 0;
  logic [AW-1:0] rsp_addr = '0;
  logic [7:0] rsp_byte = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] c_rd;
  logic c_start, c_cancel, c_cr, c_sv, c_da;
  logic [OW-1:0] c_len;

  always #2.5 clk = ~clk;

  cmd_xfer_fsm #(.BUF_BYTES(BUF), .FAMILY(FAM)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_fifo(acc_fifo), .acc_byte(acc_byte), .acc_owner(acc_owner),
    .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .be_start(be_start), .be_len(be_len), .be_cancel(be_cancel),
    .be_done(be_done), .be_selftest(be_selftest), .rsp_we(rsp_we),
    .rsp_addr(rsp_addr), .rsp_byte(rsp_byte), .evt_cmd_ready(evt_cmd_ready),
    .evt_sts_valid(evt_sts_valid), .evt_data_avail(evt_data_avail)
  );

  // status flag bytes
  localparam logic [7:0] F_VAL = 8'h80, F_CR = 8'h40, F_DA = 8'h10, F_EXP = 8'h08, F_ST = 8'h04;

  // table: status write value, whether it must act from idle
  localparam int NV = 8;
  localparam logic [31:0] VEC_W [NV] = '{32'h40, 32'h41, 32'h60, 32'h42,
                                         32'h00, 32'hFFFF_FFFF, 32'h20, 32'h02};
  localparam bit VEC_ACT [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  function automatic logic [31:0] sts(input logic [7:0] f, input int burst);
    return (32'(FAM) << 26) | (32'(burst) << 8) | 32'(f);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic capture();
    c_rd = rd_data; c_start = be_start; c_cancel = be_cancel; c_len = be_len;
    c_cr = evt_cmd_ready; c_sv = evt_sts_valid; c_da = evt_data_avail;
  endtask

  // called at a negedge, returns at the next negedge with outputs captured
  task automatic acc(input bit wr, input bit fifo, input bit own, input bit byt,
                     input logic [31:0] wd);
    acc_valid = 1; acc_write = wr; acc_fifo = fifo; acc_owner = own;
    acc_byte = byt; acc_wdata = wd;
    @(negedge clk);
    capture();
    acc_valid = 0; acc_write = 0; acc_fifo = 0; acc_byte = 0; acc_owner = 0;
  endtask

  task automatic wsts(input logic [31:0] v); acc(1, 0, 1, 0, v); endtask
  task automatic wfifo(input logic [7:0] b); acc(1, 1, 1, 0, 32'(b)); endtask
  task automatic rsts(); acc(0, 0, 1, 0, '0); endtask
  task automatic rfifo(); acc(0, 1, 1, 0, '0); endtask

  task automatic done(input bit st);
    be_done = 1; be_selftest = st;
    @(negedge clk);
    capture();
    be_done = 0; be_selftest = 0;
  endtask

  task automatic rsp_load(input logic [7:0] b [8]);
    for (int i = 0; i < 8; i++) begin
      rsp_we = 1; rsp_addr = AW'(i); rsp_byte = b[i];
      @(negedge clk);
    end
    rsp_we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rsp [8];
    logic [7:0] exp_b [8];
    rsp = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h08, 8'hAA, 8'hBB};
    exp_b = rsp;
    @(negedge clk);

    // table walk: status write filtering from idle
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wsts(VEC_W[i]);
      chk("R5 event on filtered status write", 32'(c_cr), 32'(VEC_ACT[i]));
      rsts();
      chk("R5 state after filtered status write", c_rd, sts(VEC_ACT[i] ? F_CR : 8'h00, BUF));
    end

    // reset state, family field
    do_reset();
    rsts();
    chk("R13 reset status word", c_rd, sts(8'h00, BUF));

    // non-owner accesses
    acc(1, 0, 0, 0, 32'h40);
    acc(0, 0, 0, 0, '0);
    chk("R14 non-owner status read", c_rd, 32'hFFFF_FFFF);
    acc(0, 1, 0, 0, '0);
    chk("R14 non-owner fifo read", c_rd, 32'hFF);
    rsts();
    chk("R14 non-owner write ignored", c_rd, sts(8'h00, BUF));

    // FIFO write in idle ignored
    wfifo(8'h55);
    rsts();
    chk("R2 fifo write in idle ignored", c_rd, sts(8'h00, BUF));

    // idle -> ready, then repeat
    wsts(32'h40);
    chk("R1 cmd-ready event from idle", 32'(c_cr), 1);
    wsts(32'h40);
    chk("R1 no event in ready", 32'(c_cr), 0);
    rsts();
    chk("R1 ready status", c_rd, sts(F_CR, BUF));

    // non-owner fifo write in ready ignored
    acc(1, 1, 0, 0, 32'h80);
    rsts();
    chk("R14 non-owner fifo write in ready", c_rd, sts(F_CR, BUF));

    // command of 10 bytes
    wfifo(8'h80);
    rsts();
    chk("R2 first byte enters reception", c_rd, sts(F_VAL | F_EXP, BUF - 1));
    wfifo(8'h01); wfifo(8'h00); wfifo(8'h00); wfifo(8'h00); wfifo(8'h0A);
    rsts();
    chk("R4 expect held after 6 of 10", c_rd, sts(F_VAL | F_EXP, BUF - 6));
    wfifo(8'h11); wfifo(8'h22); wfifo(8'h33);
    wsts(32'h20);
    chk("R5 go refused while expect set", 32'(c_start), 0);
    wfifo(8'h44);
    rsts();
    chk("R4 expect clears at full length", c_rd, sts(F_VAL, BUF - 10));
    wsts(32'h20);
    chk("R5 go start strobe", 32'(c_start), 1);
    chk("R5 go byte count", 32'(c_len), 10);
    wfifo(8'h99);
    rsts();
    chk("R2 fifo write in execution ignored", c_rd, sts(F_VAL, BUF - 10));
    rfifo();
    chk("R7 fifo read in execution", c_rd, 32'hFF);

    // response and done
    rsp_load(rsp);
    done(1'b1);
    chk("R6 data-available event", 32'(c_da), 1);
    chk("R6 status-valid event", 32'(c_sv), 1);
    rsts();
    chk("R6 completion status", c_rd, sts(F_VAL | F_DA | F_ST, 8));
    acc(0, 0, 1, 1, '0);
    chk("R9 byte read small burst", c_rd, sts(F_VAL | F_DA | F_ST, 8));
    for (int i = 0; i < 3; i++) begin
      rfifo();
      chk("R7 response byte", c_rd, 32'(exp_b[i]));
    end
    rsts();
    chk("R8 burst after 3 reads", c_rd, sts(F_VAL | F_DA | F_ST, 5));
    wsts(32'h02);
    rsts();
    chk("R10 retry rewinds", c_rd, sts(F_VAL | F_DA | F_ST, 8));
    for (int i = 0; i < 8; i++) begin
      rfifo();
      chk("R10 response byte after retry", c_rd, 32'(exp_b[i]));
      if (i == 7) chk("R7 last byte status-valid event", 32'(c_sv), 1);
    end
    rsts();
    chk("R7 drained status", c_rd, sts(F_VAL | F_ST, BUF - 8));
    rfifo();
    chk("R7 read past end", c_rd, 32'hFF);

    // completion -> ready
    wsts(32'h40);
    chk("R11 cmd-ready event from completion", 32'(c_cr), 1);
    rsts();
    chk("R11 ready after completion", c_rd, sts(F_CR | F_ST, BUF));

    // abort during reception
    wfifo(8'h80); wfifo(8'h01); wfifo(8'h00);
    rsts();
    chk("R13 self-test kept in reception", c_rd, sts(F_VAL | F_EXP | F_ST, BUF - 3));
    wsts(32'h40);
    chk("R12 abort in reception event", 32'(c_cr), 1);
    rsts();
    chk("R12 abort in reception status", c_rd, sts(F_CR | F_ST, BUF));

    // abort during execution
    wfifo(8'h80); wfifo(8'h01); wfifo(8'h00); wfifo(8'h00); wfifo(8'h00); wfifo(8'h06);
    rsts();
    chk("R4 six-byte packet complete", c_rd, sts(F_VAL | F_ST, BUF - 6));
    wsts(32'h20);
    chk("R5 go length six", 32'(c_len), 6);
    wsts(32'h40);
    chk("R12 cancel pulse", 32'(c_cancel), 1);
    done(1'b0);
    chk("R12 abort done cmd-ready event", 32'(c_cr), 1);
    chk("R12 abort done no data event", 32'(c_da), 0);
    rsts();
    chk("R12 ready after aborted execution", c_rd, sts(F_CR | F_ST, BUF));

    // burst cap on byte read
    acc(0, 0, 1, 1, '0);
    chk("R9 byte read caps burst", c_rd, sts(F_CR | F_ST, 255));

    // overflow: header length above buffer size
    wfifo(8'h80); wfifo(8'h01); wfifo(8'h00); wfifo(8'h00); wfifo(8'h20); wfifo(8'h00);
    for (int i = 6; i < BUF; i++) wfifo(8'(i));
    rsts();
    chk("R3 buffer full, expect held", c_rd, sts(F_VAL | F_EXP | F_ST, 0));
    wfifo(8'h77);
    rsts();
    chk("R3 overflow byte clears expect", c_rd, sts(F_VAL | F_ST, 0));
    wsts(32'h20);
    chk("R3 go with full buffer", 32'(c_len), BUF);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule